// File: doc/BRIEF.md
# Execute-Stage ALU Operand Forwarding Selector

This block picks the two ALU operands for the execute stage of a five-stage in-order pipeline. Each operand can come from one of several places. A fixed value can be forced: the program counter copy for a branch on operand 1, and the immediate constant on operand 2. Load data waiting in writeback can be fed back. Either of two ALU-result forwarding registers can be used. If none of these applies, the operand comes from the register-file latch (A or B). The block is purely combinational and also exports a 3-bit select code for each operand, so the chosen path can be seen directly.

The priority is the same for both operands. The fixed source wins first. Next comes the load data in writeback, because that value is written to the register file in this same cycle and is not held anywhere else. After that comes forwarding register 1, which is the newer one, then forwarding register 2, and last the latch. A source field that names the hardwired zero register never matches any forwarding source. This rule is turned on by a parameter.

Top module: `exop_select`

## Requirements
- R1: When `ex_is_branch` is 1, `op1` equals `pc_copy` and `sel1` is 4, whatever any other match says.
- R2: When `ex_use_imm` is 1, `op2` equals `imm_val` and `sel2` is 4, whatever any other match says.
- R3: When the fixed source does not apply, and writeback holds a load (`wb_is_load`=1, `wb_dest_valid`=1) whose `wb_dest` equals the operand's source field, the operand takes `wb_load_data` with code 3. This match beats both forwarding registers.
- R4: When R1/R2 and R3 do not apply, and `fw1_valid`=1 with `fw1_tag` equal to the source, the operand takes `fw1_data` with code 2. This match beats forwarding register 2.
- R5: When none of the above applies, and `fw2_valid`=1 with `fw2_tag` equal to the source, the operand takes `fw2_data` with code 1.
- R6: When nothing matches, operand 1 takes `opa_latch` and operand 2 takes `opb_latch`, with code 0.
- R7: If writeback is not a load, or its destination is not valid, code 3 never appears on either operand.
- R8: A forwarding register whose valid bit is 0 never matches (code 2 for register 1, code 1 for register 2).
- R9: With `ZERO_HARDWIRED`=1, a source field of 0 never matches any forwarding source. Its code is 4 or 0.
- R10: Each operand value always equals the input named by its select code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src1 | input | RIDX | First source register of the instruction in execute |
| ex_src2 | input | RIDX | Second source register of the instruction in execute |
| ex_is_branch | input | 1 | Instruction in execute is a branch |
| ex_use_imm | input | 1 | Instruction in execute uses its immediate as operand 2 |
| wb_dest | input | RIDX | Destination register of the instruction in writeback |
| wb_dest_valid | input | 1 | Writeback destination is real (not a bubble) |
| wb_is_load | input | 1 | Instruction in writeback is a load |
| wb_load_data | input | XLEN | Load data about to be written back |
| fw1_tag | input | RIDX | Destination tag of forwarding register 1 (newer) |
| fw1_valid | input | 1 | Forwarding register 1 holds a result |
| fw1_data | input | XLEN | Forwarding register 1 value |
| fw2_tag | input | RIDX | Destination tag of forwarding register 2 (older) |
| fw2_valid | input | 1 | Forwarding register 2 holds a result |
| fw2_data | input | XLEN | Forwarding register 2 value |
| opa_latch | input | XLEN | Register-file operand latch A |
| opb_latch | input | XLEN | Register-file operand latch B |
| pc_copy | input | XLEN | Program counter copy for branch targets |
| imm_val | input | XLEN | Immediate constant of the instruction in execute |
| op1 | output | XLEN | Selected first ALU operand |
| op2 | output | XLEN | Selected second ALU operand |
| sel1 | output | 3 | Select code for operand 1 |
| sel2 | output | 3 | Select code for operand 2 |

## Verification
Two functions can apply in the same cycle. The load-data feedback from writeback and the ALU-result forwarding registers can both claim the same source register. The same goes for a branch or immediate override arriving while forwarding matches are live. The sweep sets the writeback destination and both tags to every combination of register numbers while toggling the load, valid, branch and immediate flags. In each pattern the code and value must match the highest-priority rule that applies, so any case where load data and a forwarding register both match shows whether the load data wins.

// File: rtl/exop_select.sv
module exop_select #(
  parameter int XLEN = 32,
  parameter int RIDX = 5,
  parameter bit ZERO_HARDWIRED = 1'b1
) (
  input  logic [RIDX-1:0] ex_src1,
  input  logic [RIDX-1:0] ex_src2,
  input  logic            ex_is_branch,
  input  logic            ex_use_imm,
  input  logic [RIDX-1:0] wb_dest,
  input  logic            wb_dest_valid,
  input  logic            wb_is_load,
  input  logic [XLEN-1:0] wb_load_data,
  input  logic [RIDX-1:0] fw1_tag,
  input  logic            fw1_valid,
  input  logic [XLEN-1:0] fw1_data,
  input  logic [RIDX-1:0] fw2_tag,
  input  logic            fw2_valid,
  input  logic [XLEN-1:0] fw2_data,
  input  logic [XLEN-1:0] opa_latch,
  input  logic [XLEN-1:0] opb_latch,
  input  logic [XLEN-1:0] pc_copy,
  input  logic [XLEN-1:0] imm_val,
  output logic [XLEN-1:0] op1,
  output logic [XLEN-1:0] op2,
  output logic [2:0]      sel1,
  output logic [2:0]      sel2
);

  localparam logic [2:0] SEL_REG   = 3'd0;
  localparam logic [2:0] SEL_FW2   = 3'd1;
  localparam logic [2:0] SEL_FW1   = 3'd2;
  localparam logic [2:0] SEL_LD    = 3'd3;
  localparam logic [2:0] SEL_FIXED = 3'd4;

  function automatic logic hit(input logic [RIDX-1:0] src,
                               input logic [RIDX-1:0] tag,
                               input logic            vld);
    return vld && (src == tag) && !(ZERO_HARDWIRED && (src == '0));
  endfunction

  function automatic logic [2:0] pick(input logic            fixed,
                                      input logic [RIDX-1:0] src,
                                      input logic            ld_ok,
                                      input logic [RIDX-1:0] ld_tag,
                                      input logic [RIDX-1:0] t1,
                                      input logic            v1,
                                      input logic [RIDX-1:0] t2,
                                      input logic            v2);
    if (fixed)                 return SEL_FIXED;
    if (hit(src, ld_tag, ld_ok)) return SEL_LD;
    if (hit(src, t1, v1))      return SEL_FW1;
    if (hit(src, t2, v2))      return SEL_FW2;
    return SEL_REG;
  endfunction

  logic wb_ld_live;
  assign wb_ld_live = wb_is_load & wb_dest_valid;

  assign sel1 = pick(ex_is_branch, ex_src1, wb_ld_live, wb_dest,
                     fw1_tag, fw1_valid, fw2_tag, fw2_valid);
  assign sel2 = pick(ex_use_imm, ex_src2, wb_ld_live, wb_dest,
                     fw1_tag, fw1_valid, fw2_tag, fw2_valid);

  always_comb begin
    case (sel1)
      SEL_FIXED: op1 = pc_copy;
      SEL_LD:    op1 = wb_load_data;
      SEL_FW1:   op1 = fw1_data;
      SEL_FW2:   op1 = fw2_data;
      default:   op1 = opa_latch;
    endcase
  end

  always_comb begin
    case (sel2)
      SEL_FIXED: op2 = imm_val;
      SEL_LD:    op2 = wb_load_data;
      SEL_FW1:   op2 = fw1_data;
      SEL_FW2:   op2 = fw2_data;
      default:   op2 = opb_latch;
    endcase
  end

endmodule

// File: rtl/exop_select_chk.sv
module exop_select_chk #(
  parameter int XLEN = 32,
  parameter int RIDX = 5,
  parameter bit ZERO_HARDWIRED = 1'b1
) (
  input logic [RIDX-1:0] ex_src1,
  input logic [RIDX-1:0] ex_src2,
  input logic            ex_is_branch,
  input logic            ex_use_imm,
  input logic [RIDX-1:0] wb_dest,
  input logic            wb_dest_valid,
  input logic            wb_is_load,
  input logic [XLEN-1:0] wb_load_data,
  input logic [RIDX-1:0] fw1_tag,
  input logic            fw1_valid,
  input logic [XLEN-1:0] fw1_data,
  input logic [RIDX-1:0] fw2_tag,
  input logic            fw2_valid,
  input logic [XLEN-1:0] fw2_data,
  input logic [XLEN-1:0] opa_latch,
  input logic [XLEN-1:0] opb_latch,
  input logic [XLEN-1:0] pc_copy,
  input logic [XLEN-1:0] imm_val,
  input logic [XLEN-1:0] op1,
  input logic [XLEN-1:0] op2,
  input logic [2:0]      sel1,
  input logic [2:0]      sel2
);

  always_comb begin
    if (ex_is_branch)
      p_branch_pc_r1: assert (sel1 == 3'd4 && op1 == pc_copy);
    if (ex_use_imm)
      p_imm_const_r2: assert (sel2 == 3'd4 && op2 == imm_val);
    if (!ex_is_branch && wb_is_load && wb_dest_valid && ex_src1 == wb_dest &&
        !(ZERO_HARDWIRED && ex_src1 == '0))
      p_load_first_r3: assert (sel1 == 3'd3);
    if (!(wb_is_load && wb_dest_valid))
      p_no_stale_load_r7: assert (sel1 != 3'd3 && sel2 != 3'd3);
    if (!fw1_valid)
      p_fw1_gate_r8: assert (sel1 != 3'd2 && sel2 != 3'd2);
    if (!fw2_valid)
      p_fw2_gate_r8: assert (sel1 != 3'd1 && sel2 != 3'd1);
    if (ZERO_HARDWIRED && ex_src1 == '0)
      p_zero_src1_r9: assert (sel1 == 3'd4 || sel1 == 3'd0);
    if (ZERO_HARDWIRED && ex_src2 == '0)
      p_zero_src2_r9: assert (sel2 == 3'd4 || sel2 == 3'd0);
    p_code_range_r10: assert (sel1 <= 3'd4 && sel2 <= 3'd4);
    if (sel1 == 3'd0)
      p_latch_a_r6: assert (op1 == opa_latch);
    if (sel2 == 3'd0)
      p_latch_b_r6: assert (op2 == opb_latch);
    if (sel1 == 3'd3)
      p_ld_val_r10: assert (op1 == wb_load_data);
    if (sel2 == 3'd2)
      p_fw1_val_r4: assert (op2 == fw1_data);
    if (sel2 == 3'd1)
      p_fw2_val_r5: assert (op2 == fw2_data);
  end

endmodule

bind exop_select exop_select_chk #(
  .XLEN(XLEN), .RIDX(RIDX), .ZERO_HARDWIRED(ZERO_HARDWIRED)
) u_chk (.*);

// File: tb/exop_select_bench.sv
module exop_select_bench;
  localparam int XLEN = 16;
  localparam int RIDX = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [RIDX-1:0] ex_src1, ex_src2, wb_dest, fw1_tag, fw2_tag;
  logic ex_is_branch, ex_use_imm, wb_dest_valid, wb_is_load, fw1_valid, fw2_valid;
  logic [XLEN-1:0] wb_load_data, fw1_data, fw2_data, opa_latch, opb_latch, pc_copy, imm_val;
  logic [XLEN-1:0] op1, op2;
  logic [2:0] sel1, sel2;

  exop_select #(.XLEN(XLEN), .RIDX(RIDX), .ZERO_HARDWIRED(1'b1)) u_exop_select (.*);

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  localparam logic [XLEN-1:0] V_PC = 16'h1111, V_IMM = 16'h2222, V_LD = 16'h3333,
                              V_F1 = 16'h4444, V_F2 = 16'h5555, V_A = 16'h6666, V_B = 16'h7777;

  function automatic int exp_code(bit fixed, int src, bit ldok, int wbd,
                                  int t1, bit v1, int t2, bit v2);
    if (fixed) return 4;
    if (src == 0) return 0;
    if (ldok && src == wbd) return 3;
    if (v1 && src == t1) return 2;
    if (v2 && src == t2) return 1;
    return 0;
  endfunction

  function automatic logic [XLEN-1:0] exp_val(int code, bit first);
    case (code)
      4: return first ? V_PC : V_IMM;
      3: return V_LD;
      2: return V_F1;
      1: return V_F2;
      default: return first ? V_A : V_B;
    endcase
  endfunction

  function automatic string tag_of(int code, bit first);
    case (code)
      4: return first ? "R1" : "R2";
      3: return "R3";
      2: return "R4";
      1: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string req, int got_c, int exp_c, logic [XLEN-1:0] got_v, logic [XLEN-1:0] exp_v);
    total++;
    if (got_c != exp_c || got_v != exp_v) begin
      bad++;
      $display("FAIL %s: code=%0d value=%h expected code=%0d value=%h", req, got_c, got_v, exp_c, exp_v);
    end
  endtask

  task automatic apply(int s1, int s2, bit br, bit im, int wbd, bit wbv, bit wbl,
                       int t1, bit v1, int t2, bit v2);
    @(posedge clk);
    ex_src1 = RIDX'(s1); ex_src2 = RIDX'(s2); ex_is_branch = br; ex_use_imm = im;
    wb_dest = RIDX'(wbd); wb_dest_valid = wbv; wb_is_load = wbl;
    fw1_tag = RIDX'(t1); fw1_valid = v1; fw2_tag = RIDX'(t2); fw2_valid = v2;
    @(negedge clk);
  endtask

  task automatic judge(string req, int s1, int s2, bit br, bit im, int wbd, bit ldok,
                       int t1, bit v1, int t2, bit v2);
    int c1, c2;
    c1 = exp_code(br, s1, ldok, wbd, t1, v1, t2, v2);
    c2 = exp_code(im, s2, ldok, wbd, t1, v1, t2, v2);
    check(req.len() ? req : tag_of(c1, 1'b1), int'(sel1), c1, op1, exp_val(c1, 1'b1));
    check(req.len() ? req : tag_of(c2, 1'b0), int'(sel2), c2, op2, exp_val(c2, 1'b0));
  endtask

  initial begin
    wb_load_data = V_LD; fw1_data = V_F1; fw2_data = V_F2;
    opa_latch = V_A; opb_latch = V_B; pc_copy = V_PC; imm_val = V_IMM;
    ex_src1 = '0; ex_src2 = '0; ex_is_branch = 0; ex_use_imm = 0;
    wb_dest = '0; wb_dest_valid = 0; wb_is_load = 0;
    fw1_tag = '0; fw1_valid = 0; fw2_tag = '0; fw2_valid = 0;
    @(negedge clk);
    // R6: quiet state selects the latches
    check("R6", int'(sel1), 0, op1, V_A);
    check("R6", int'(sel2), 0, op2, V_B);

    // R3/R4/R5: every source claims r5 at once; load data wins
    apply(5, 5, 0, 0, 5, 1, 1, 5, 1, 5, 1);
    judge("R3", 5, 5, 0, 0, 5, 1, 5, 1, 5, 1);
    // R7: store in writeback and bubble in writeback never forward
    apply(5, 5, 0, 0, 5, 1, 0, 6, 1, 6, 1);
    judge("R7", 5, 5, 0, 0, 5, 0, 6, 1, 6, 1);
    apply(5, 5, 0, 0, 5, 0, 1, 6, 1, 6, 1);
    judge("R7", 5, 5, 0, 0, 5, 0, 6, 1, 6, 1);
    // R8: invalid fw1 with matching tag falls through to fw2
    apply(3, 3, 0, 0, 1, 1, 1, 3, 0, 3, 1);
    judge("R8", 3, 3, 0, 0, 1, 1, 3, 0, 3, 1);
    // R9: zero source never forwards even when all match
    apply(0, 0, 0, 0, 0, 1, 1, 0, 1, 0, 1);
    judge("R9", 0, 0, 0, 0, 0, 1, 0, 1, 0, 1);
    // R1/R2 override a load match
    apply(2, 2, 1, 1, 2, 1, 1, 2, 1, 2, 1);
    judge("R1", 2, 2, 1, 1, 2, 1, 2, 1, 2, 1);

    for (int s1 = 0; s1 < 8; s1++)
      for (int wbd = 0; wbd < 8; wbd++)
        for (int t1 = 0; t1 < 8; t1++)
          for (int t2 = 0; t2 < 8; t2++)
            for (int k = 0; k < 32; k++) begin
              int s2;
              bit br, im, wbl, v1, v2;
              s2 = (s1 + t2 + k) % 8;
              br = k[0]; im = k[1]; wbl = k[2]; v1 = k[3]; v2 = k[4];
              apply(s1, s2, br, im, wbd, 1'b1, wbl, t1, v1, t2, v2);
              // R10: value always matches the selected input
              judge("", s1, s2, br, im, wbd, wbl, t1, v1, t2, v2);
            end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule